// File: doc/BRIEF.md
# SD Host Normal Interrupt Status and Software Reset Controller

This block keeps the normal interrupt status of an SD-style host controller, the three self-clearing software reset controls, and the single interrupt line that software sees. One-cycle event pulses from the command and data engines are caught in sticky status bits. The card interrupt is carried as a live level. A status-enable mask decides what a read of the status register returns. A separate signal-enable mask decides which of those visible bits can raise the interrupt line. Software clears status bits by writing ones to them.

The same register bus also holds a small present-state register, which the engines update through set and clear strobes, and a two-bit block-gap request register. Each software reset is started by writing a 1 to its bit. The bit then stays set for a parameterised number of cycles, and during that time only its own slice of state is held at zero. The reset outputs go to the command engine, and to the data and DMA logic. The full reset additionally waits for the capabilities logic to report ready before its bit falls. Register reads are combinational from the current address. Writes take effect on the rising clock edge where `bus_wen` is high. The interface carries no data stream, so every pin is a plain control or status level with no handshake.

Top module: `sdh_irq_rst_ctl`

## Requirements
- R1: After `rst_n` is released, every register reads 0, `irq` is 0, and all three reset outputs are 0.
- R2: A 1 on `ev_pulse[k]` (k = 0..5) sets status bit k at the next edge, and the bit stays set until it is cleared. The bit map is 0 command complete, 1 transfer complete, 2 block gap event, 3 DMA interrupt, 4 buffer write ready, 5 buffer read ready.
- R3: A write to the status register (0x30) clears each bit 0..5 where the written data has a 1. Bits written with 0 keep their value. One write can clear several bits.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: Status bit 8 follows the `card_irq` level. Writing 1 to that bit has no effect. Bits 6, 7 and 9..15 always read 0.
- R6: A read of the status register returns the status bits ANDed with the status-enable register (0x34, writable bits 0..5 and 8). The signal-enable register (0x38) has no effect on the value read.
- R7: `irq` is 1 exactly when the status read value ANDed with the signal-enable register is nonzero. It follows a register change at the edge where that change happens.
- R8: The reset register is at 0x2C, with bit 0 for the full reset, bit 1 for the command reset and bit 2 for the data reset. Writing a 1 to a bit makes it read 1 for exactly RST_CYCLES cycles (default 4), after which it returns to 0. Writing 0 has no effect. `rst_cmd_o` is high while the command or full reset is active. `rst_dat_o` (data and DMA) is high while the data or full reset is active.
- R9: The command reset clears only status bit 0 and present-state command inhibit. All other status, present-state and gap bits keep their values.
- R10: The data reset clears status bits 1..5, the present-state bits other than command inhibit, and both gap request bits. Event pulses that arrive while it is active are dropped.
- R11: The full reset clears all status bits, both enable registers, the present state and the gap bits, and it drives both reset outputs. Its bit stays 1 for as long as `caps_ready` is 0, and it falls once `caps_ready` is 1 after the minimum time. The live card interrupt level is not affected by it.
- R12: The present-state register (0x24) is set by `ps_set[j]` and cleared by `ps_clr[j]`, and set wins when both arrive together. Read bits are: j=0 to bit 0 (command inhibit), j=1 to bit 1 (data inhibit), j=2 to bit 2 (data line active), j=3..6 to bits 8..11 (write active, read active, buffer write enable, buffer read enable).
- R13: The gap request register (0x28) stores bits 0 (stop request) and 1 (continue request), and its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| ev_pulse | input | 6 | Status event pulses from the engines |
| card_irq | input | 1 | Live card interrupt level |
| ps_set | input | 7 | Present-state set strobes |
| ps_clr | input | 7 | Present-state clear strobes |
| caps_ready | input | 1 | Capabilities valid, allows the full reset to finish |
| irq | output | 1 | Interrupt line |
| rst_all_o | output | 1 | Full software reset active |
| rst_cmd_o | output | 1 | Command engine reset |
| rst_dat_o | output | 1 | Data and DMA reset |

## Verification
The bench goes through all 64 status patterns, each cleared with a different write mask, so a design that cleared bits it was not asked to clear, or that left bits set, shows up as a wrong readback. It drives an event and a clearing write on the same bit in the same cycle, where a clear-wins design would lose the event. It sweeps the status-enable and signal-enable masks against each other to catch a design that masks the read with the wrong register, or gates the interrupt line with only one of them. Each reset is timed cycle by cycle and its effect is checked bit by bit. A leaky reset would clear a neighbour's bits, an off-by-one counter would change how long the bit is high, and a full reset that ignored `caps_ready` would fall too early.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int N_EVT  = 6;
  localparam int N_PS   = 7;
  localparam int N_RST  = 3;
  localparam int N_GAP  = 2;
  localparam int CARD_BIT = 8;

  localparam logic [ADDR_W-1:0] A_PSTATE = 8'h24;
  localparam logic [ADDR_W-1:0] A_GAP    = 8'h28;
  localparam logic [ADDR_W-1:0] A_RST    = 8'h2C;
  localparam logic [ADDR_W-1:0] A_STAT   = 8'h30;
  localparam logic [ADDR_W-1:0] A_STEN   = 8'h34;
  localparam logic [ADDR_W-1:0] A_SIGEN  = 8'h38;

  // reset channel indices (bit positions in the reset register)
  localparam int RI_ALL = 0;
  localparam int RI_CMD = 1;
  localparam int RI_DAT = 2;

  // status bits owned by each partial reset
  localparam logic [N_EVT-1:0] CMD_STAT_MASK = 6'b000001;
  localparam logic [N_EVT-1:0] DAT_STAT_MASK = 6'b111110;
  localparam logic [N_PS-1:0]  CMD_PS_MASK   = 7'b0000001;
  localparam logic [N_PS-1:0]  DAT_PS_MASK   = 7'b1111110;

  // writable bits of the enable registers
  localparam logic [DATA_W-1:0] EN_VALID =
    (DATA_W'(1) << CARD_BIT) | DATA_W'((1 << N_EVT) - 1);

  typedef struct packed {
    logic all;
    logic cmd;
    logic dat;
  } clr_req_t;

  function automatic logic [DATA_W-1:0] ps_pack(input logic [N_PS-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[2:0]  = v[2:0];
    r[11:8] = v[6:3];
    return r;
  endfunction
endpackage

// File: rtl/sdh_rst_seq.sv
module sdh_rst_seq #(
  parameter int RST_CYCLES = 4,
  localparam int CW = $clog2(RST_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic gate,
  output logic active
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        cnt    <= CW'(RST_CYCLES - 1);
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else if (gate) begin
      active <= 1'b0;
    end
  end
endmodule

// File: rtl/sdh_status_bank.sv
module sdh_status_bank
  import sdh_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EVT-1:0]  ev,
  input  logic              card_irq,
  input  logic              wr_stat,
  input  logic              wr_sten,
  input  logic              wr_sigen,
  input  logic [DATA_W-1:0] wdata,
  input  clr_req_t          clr,
  output logic [N_EVT-1:0]  raw_q,
  output logic [DATA_W-1:0] sten_q,
  output logic [DATA_W-1:0] sigen_q,
  output logic [DATA_W-1:0] rd_stat,
  output logic              irq
);
  logic [N_EVT-1:0]  w1c;
  logic [N_EVT-1:0]  hold_zero;
  logic [N_EVT-1:0]  raw_nxt;
  logic [DATA_W-1:0] full;

  always_comb begin
    w1c       = wr_stat ? wdata[N_EVT-1:0] : '0;
    hold_zero = '0;
    if (clr.all) hold_zero = '1;
    if (clr.cmd) hold_zero = hold_zero | CMD_STAT_MASK;
    if (clr.dat) hold_zero = hold_zero | DAT_STAT_MASK;
    raw_nxt   = ((raw_q & ~w1c) | ev) & ~hold_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q   <= '0;
      sten_q  <= '0;
      sigen_q <= '0;
    end else begin
      raw_q <= raw_nxt;
      if (clr.all) begin
        sten_q  <= '0;
        sigen_q <= '0;
      end else begin
        if (wr_sten)  sten_q  <= wdata & EN_VALID;
        if (wr_sigen) sigen_q <= wdata & EN_VALID;
      end
    end
  end

  always_comb begin
    full              = '0;
    full[N_EVT-1:0]   = raw_q;
    full[CARD_BIT]    = card_irq;
    rd_stat           = full & sten_q;
    irq               = |(rd_stat & sigen_q);
  end
endmodule

// File: rtl/sdh_pstate.sv
module sdh_pstate
  import sdh_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PS-1:0]   ps_set,
  input  logic [N_PS-1:0]   ps_clr,
  input  logic              wr_gap,
  input  logic [DATA_W-1:0] wdata,
  input  clr_req_t          clr,
  output logic [N_PS-1:0]   ps_q,
  output logic [N_GAP-1:0]  gap_q
);
  logic [N_PS-1:0] hold_zero;

  always_comb begin
    hold_zero = '0;
    if (clr.all) hold_zero = '1;
    if (clr.cmd) hold_zero = hold_zero | CMD_PS_MASK;
    if (clr.dat) hold_zero = hold_zero | DAT_PS_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_q  <= '0;
      gap_q <= '0;
    end else begin
      ps_q <= ((ps_q & ~ps_clr) | ps_set) & ~hold_zero;
      if (clr.all || clr.dat) gap_q <= '0;
      else if (wr_gap)        gap_q <= wdata[N_GAP-1:0];
    end
  end
endmodule

// File: rtl/sdh_irq_rst_ctl.sv
module sdh_irq_rst_ctl
  import sdh_irq_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_EVT-1:0]  ev_pulse,
  input  logic              card_irq,
  input  logic [N_PS-1:0]   ps_set,
  input  logic [N_PS-1:0]   ps_clr,
  input  logic              caps_ready,
  output logic              irq,
  output logic              rst_all_o,
  output logic              rst_cmd_o,
  output logic              rst_dat_o
);
  logic              wr_stat, wr_sten, wr_sigen, wr_gap, wr_rst;
  logic [N_RST-1:0]  act;
  clr_req_t          clr;
  logic [N_EVT-1:0]  stat_raw;
  logic [DATA_W-1:0] sten_q, sigen_q, rd_stat;
  logic [N_PS-1:0]   ps_q;
  logic [N_GAP-1:0]  gap_q;

  assign wr_stat  = bus_wen && (bus_addr == A_STAT);
  assign wr_sten  = bus_wen && (bus_addr == A_STEN);
  assign wr_sigen = bus_wen && (bus_addr == A_SIGEN);
  assign wr_gap   = bus_wen && (bus_addr == A_GAP);
  assign wr_rst   = bus_wen && (bus_addr == A_RST);

  for (genvar i = 0; i < N_RST; i++) begin : g_rst
    sdh_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (wr_rst && bus_wdata[i]),
      .gate   ((i == RI_ALL) ? caps_ready : 1'b1),
      .active (act[i])
    );
  end

  assign clr.all = act[RI_ALL];
  assign clr.cmd = act[RI_CMD];
  assign clr.dat = act[RI_DAT];

  assign rst_all_o = act[RI_ALL];
  assign rst_cmd_o = act[RI_ALL] | act[RI_CMD];
  assign rst_dat_o = act[RI_ALL] | act[RI_DAT];

  sdh_status_bank u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev_pulse),
    .card_irq (card_irq),
    .wr_stat  (wr_stat),
    .wr_sten  (wr_sten),
    .wr_sigen (wr_sigen),
    .wdata    (bus_wdata),
    .clr      (clr),
    .raw_q    (stat_raw),
    .sten_q   (sten_q),
    .sigen_q  (sigen_q),
    .rd_stat  (rd_stat),
    .irq      (irq)
  );

  sdh_pstate u_ps (
    .clk    (clk),
    .rst_n  (rst_n),
    .ps_set (ps_set),
    .ps_clr (ps_clr),
    .wr_gap (wr_gap),
    .wdata  (bus_wdata),
    .clr    (clr),
    .ps_q   (ps_q),
    .gap_q  (gap_q)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_PSTATE: bus_rdata = ps_pack(ps_q);
      A_GAP:    bus_rdata[N_GAP-1:0] = gap_q;
      A_RST:    bus_rdata[N_RST-1:0] = act;
      A_STAT:   bus_rdata = rd_stat;
      A_STEN:   bus_rdata = sten_q;
      A_SIGEN:  bus_rdata = sigen_q;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sdh_irq_rst_chk.sv
module sdh_irq_rst_chk
  import sdh_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wen,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [N_EVT-1:0]  ev_pulse,
  input logic              caps_ready,
  input logic              irq,
  input logic              rst_all_o,
  input logic              rst_cmd_o,
  input logic              rst_dat_o,
  input logic [N_EVT-1:0]  stat_raw,
  input logic [DATA_W-1:0] sten_q,
  input logic [DATA_W-1:0] sigen_q
);
  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wen && bus_addr == A_STAT && ev_pulse == '0)
      |=> ((stat_raw & $past(bus_wdata[N_EVT-1:0])) == '0));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ev_pulse) && !rst_cmd_o && !rst_dat_o)
      |=> ((stat_raw & $past(ev_pulse)) == $past(ev_pulse)));

  // R7
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sten_q & sigen_q) == '0) |-> !irq);

  // R11
  all_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_all_o && !caps_ready) |=> rst_all_o);

  // R9
  cmd_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_cmd_o && !rst_dat_o && !bus_wen)
      |=> ((stat_raw[N_EVT-1:1] & $past(stat_raw[N_EVT-1:1])) == $past(stat_raw[N_EVT-1:1])));

  // R10
  dat_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_dat_o |=> (stat_raw[N_EVT-1:1] == '0));
endmodule

bind sdh_irq_rst_ctl sdh_irq_rst_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wen    (bus_wen),
  .bus_wdata  (bus_wdata),
  .ev_pulse   (ev_pulse),
  .caps_ready (caps_ready),
  .irq        (irq),
  .rst_all_o  (rst_all_o),
  .rst_cmd_o  (rst_cmd_o),
  .rst_dat_o  (rst_dat_o),
  .stat_raw   (stat_raw),
  .sten_q     (sten_q),
  .sigen_q    (sigen_q)
);

// File: tb/sim_sdh_irq_rst_ctl.sv
module sim_sdh_irq_rst_ctl;
  localparam int RSTC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wen = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [5:0]  ev = '0;
  logic        card = 1'b0;
  logic [6:0]  pss = '0;
  logic [6:0]  psc = '0;
  logic        caps = 1'b1;
  logic        irq, r_all, r_cmd, r_dat;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sdh_irq_rst_ctl #(.RST_CYCLES(RSTC)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wen(wen),
    .bus_wdata(wdata), .bus_rdata(rdata), .ev_pulse(ev), .card_irq(card),
    .ps_set(pss), .ps_clr(psc), .caps_ready(caps), .irq(irq),
    .rst_all_o(r_all), .rst_cmd_o(r_cmd), .rst_dat_o(r_dat)
  );

  function automatic logic [15:0] pmap(input logic [6:0] v);
    return {4'b0, v[6:3], 5'b0, v[2:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    addr = a; wdata = d; wen = 1'b1;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic pulse(input logic [5:0] m);
    ev = m;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic ps_all;
    pss = 7'h7F;
    @(negedge clk);
    pss = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(8'h30, v); chk("R1 stat", v, 0);
    rd(8'h34, v); chk("R1 sten", v, 0);
    rd(8'h38, v); chk("R1 sigen", v, 0);
    rd(8'h2C, v); chk("R1 rst", v, 0);
    rd(8'h24, v); chk("R1 pstate", v, 0);
    rd(8'h28, v); chk("R1 gap", v, 0);
    chk("R1 outs", {irq, r_all, r_cmd, r_dat}, 0);

    wr(8'h34, 16'hFFFF);
    rd(8'h34, v); chk("R6 sten writable bits", v, 16'h013F);

    // R2 / R3 sweep
    for (int m = 0; m < 64; m++) begin
      logic [5:0] w;
      w = 6'((m * 37 + 11) & 63);
      pulse(6'(m));
      rd(8'h30, v); chk("R2 latch", v, 16'(m));
      wr(8'h30, {10'h3FF, w});
      rd(8'h30, v); chk("R3 w1c", v, 16'(m & ~int'(w) & 63));
      wr(8'h30, 16'h003F);
      rd(8'h30, v); chk("R3 clear all", v, 0);
    end

    // R4 set beats clear
    for (int b = 0; b < 6; b++) begin
      ev = 6'(1 << b); addr = 8'h30; wdata = 16'h003F; wen = 1'b1;
      @(negedge clk);
      ev = '0; wen = 1'b0;
      rd(8'h30, v); chk("R4 set wins", v, 16'(1 << b));
      wr(8'h30, 16'h003F);
    end

    // R6 status enable sweep, signal enable has no effect on read
    pulse(6'h3F);
    for (int e = 0; e < 64; e++) begin
      wr(8'h34, 16'(e));
      wr(8'h38, 16'(63 - e));
      rd(8'h30, v); chk("R6 masked read", v, 16'(e));
    end

    // R7 interrupt gating sweep
    for (int k = 0; k < 4; k++) begin
      logic [5:0] e;
      e = (k == 0) ? 6'h01 : (k == 1) ? 6'h15 : (k == 2) ? 6'h2A : 6'h3F;
      wr(8'h34, {10'h0, e});
      for (int s = 0; s < 64; s++) begin
        wr(8'h38, 16'(s));
        chk("R7 irq", irq, |(e & 6'(s)));
      end
    end

    // R5 card interrupt level
    wr(8'h30, 16'h003F);
    wr(8'h34, 16'h0100);
    wr(8'h38, 16'h0100);
    chk("R5 card off irq", irq, 0);
    card = 1'b1;
    #1;
    rd(8'h30, v); chk("R5 card on", v, 16'h0100);
    chk("R5 card irq", irq, 1);
    wr(8'h30, 16'hFFFF);
    rd(8'h30, v); chk("R5 w1 ignored", v, 16'h0100);
    card = 1'b0;
    #1;
    rd(8'h30, v); chk("R5 card drop", v, 0);
    wr(8'h34, 16'h013F);
    wr(8'h38, 16'h0000);

    // R12 present state
    for (int j = 0; j < 7; j++) begin
      pss = 7'(1 << j);
      @(negedge clk); pss = '0;
      rd(8'h24, v); chk("R12 set", v, pmap(7'(1 << j)));
      pss = 7'(1 << j); psc = 7'(1 << j);
      @(negedge clk); pss = '0; psc = '0;
      rd(8'h24, v); chk("R12 set wins", v, pmap(7'(1 << j)));
      psc = 7'(1 << j);
      @(negedge clk); psc = '0;
      rd(8'h24, v); chk("R12 clr", v, 0);
    end

    // R13 gap register
    wr(8'h28, 16'hFFFF);
    rd(8'h28, v); chk("R13 gap", v, 16'h0003);
    wr(8'h28, 16'h0001);
    rd(8'h28, v); chk("R13 gap stop", v, 16'h0001);
    wr(8'h28, 16'h0003);

    // R8 write zero has no effect
    pulse(6'h3F); ps_all;
    wr(8'h2C, 16'h0000);
    rd(8'h2C, v); chk("R8 write zero", v, 0);
    rd(8'h30, v); chk("R8 write zero keeps", v, 16'h003F);

    // R8 / R9 command reset
    wr(8'h2C, 16'h0002);
    for (int i = 0; i < RSTC; i++) begin
      rd(8'h2C, v); chk("R8 cmd bit high", v, 16'h0002);
      chk("R8 cmd outs", {r_all, r_cmd, r_dat}, 3'b010);
      @(negedge clk);
    end
    rd(8'h2C, v); chk("R8 cmd self clear", v, 0);
    chk("R8 cmd out low", r_cmd, 0);
    rd(8'h30, v); chk("R9 cmd status", v, 16'h003E);
    rd(8'h24, v); chk("R9 cmd pstate", v, pmap(7'h7E));
    rd(8'h28, v); chk("R9 cmd gap kept", v, 16'h0003);

    // R10 data reset
    pulse(6'h3F); ps_all;
    wr(8'h2C, 16'h0004);
    for (int i = 0; i < RSTC; i++) begin
      rd(8'h2C, v); chk("R8 dat bit high", v, 16'h0004);
      chk("R10 dat outs", {r_all, r_cmd, r_dat}, 3'b001);
      if (i == 1) pulse(6'h02); else @(negedge clk);
    end
    rd(8'h2C, v); chk("R8 dat self clear", v, 0);
    rd(8'h30, v); chk("R10 dat status", v, 16'h0001);
    rd(8'h24, v); chk("R10 dat pstate", v, pmap(7'h01));
    rd(8'h28, v); chk("R10 dat gap", v, 0);

    // R11 full reset held by caps_ready
    pulse(6'h3F); ps_all;
    wr(8'h28, 16'h0003);
    wr(8'h38, 16'h013F);
    card = 1'b1;
    caps = 1'b0;
    wr(8'h2C, 16'h0001);
    for (int i = 0; i < RSTC + 4; i++) begin
      rd(8'h2C, v); chk("R11 all bit held", v, 16'h0001);
      chk("R11 all outs", {r_all, r_cmd, r_dat}, 3'b111);
      @(negedge clk);
    end
    caps = 1'b1;
    @(negedge clk);
    rd(8'h2C, v); chk("R11 all self clear", v, 0);
    chk("R11 outs low", {r_all, r_cmd, r_dat}, 0);
    rd(8'h34, v); chk("R11 sten cleared", v, 0);
    rd(8'h38, v); chk("R11 sigen cleared", v, 0);
    rd(8'h24, v); chk("R11 pstate cleared", v, 0);
    rd(8'h28, v); chk("R11 gap cleared", v, 0);
    chk("R11 irq low", irq, 0);
    wr(8'h34, 16'h013F);
    rd(8'h30, v); chk("R11 status cleared, card kept", v, 16'h0100);
    card = 1'b0;

    done = 1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule